// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. It covers both register writes and register reads. A host presents one request on a valid/ready channel. The request carries a write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then owns the bus until the transaction ends:

- It derives the management clock from the system clock through a half-period divider.
- It drives a 32-bit all-ones preamble.
- It drives the command bits most significant first.
- For a read, it releases the data line and captures the PHY's answer.
- It always finishes with a 32-bit all-ones idle tail before it accepts anything else.

The data pin is modelled as separate output, output-enable and input signals, so a pad or open-drain cell can be placed around it. The request channel follows valid/ready rules. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low for the whole transaction, and any `req_valid` seen in that time has no effect. The host may hold its request for as long as it likes. The response is a single-cycle `rsp_valid` pulse with no back-pressure, and `rsp_rdata` carries the read result in that cycle.

Every transaction is exactly 96 bit times long, whether it is a read or a write:

| Transaction | Preamble | Command | Released for capture | Idle tail |
|---|---|---|---|---|
| Write | 32 | 32 | 0 | 32 |
| Read | 32 | 14 | 18 | 32 |

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, and whenever no transaction is active, `mdc` is high, `mdio_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. From the next cycle `req_ready` stays low until the transaction ends, and requests presented meanwhile change nothing on the bus or in the response.
- R3: Each bit time is a low phase of `HALF_DIV` cycles followed by a high phase of `HALF_DIV` cycles. The first low phase begins in the cycle after acceptance. `mdio_o` changes only as `mdc` goes low, never while `mdc` is high.
- R4: Bit times 0 to 31 drive `mdio_o` = 1 with `mdio_oe` = 1 (preamble).
- R5: A write then drives 32 bits, most significant first: 01, then 01, then the PHY address, then the register address, then 10, then the 16 data bits.
- R6: A read drives only the first 14 bits of the same layout with opcode 10 (01, 10, PHY address, register address). It then holds `mdio_oe` = 0 for bit times 46 to 63. Writes never deassert `mdio_oe` during a transaction.
- R7: During each of the 18 released bit times, `mdio_i` is sampled in the last cycle of the low phase and shifted in at the least significant end. `rsp_rdata` returns the last 16 samples, so the first two are discarded.
- R8: Bit times 64 to 95 drive `mdio_o` = 1 with `mdio_oe` = 1 and `mdc` toggling, for reads and writes alike.
- R9: `rsp_valid` is high for exactly one cycle, the cycle after the final high phase ends (cycle 192*`HALF_DIV` counted from the first low phase). A new request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid after a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value observed on the data line |

## Verification
The hardest situation to reach from the ports is the read capture. The PHY value has to be present in exactly the last low-phase cycle of each of the 18 released bit times. The first two samples must then fall off the result. The bench solves this by making its PHY model a function of the reference cycle count. It presents bit 17-k of a known 18-bit pattern in low phase k of the release window. It then expects the low 16 bits of that pattern back, using patterns whose top two bits differ from the bits that are kept.

Two further cases are driven on purpose. A spurious request with different fields is raised in the middle of every transaction. A request is also offered in the completion cycle itself, to reach the back-to-back acceptance case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_BITS    = 32;
  localparam int TAIL_BITS   = 32;
  localparam int FRAME_BITS  = 32;
  localparam int RD_CMD_BITS = 4 + 2 * ADDR_W;
  localparam int CAP_BITS    = DATA_W + 2;
  localparam int SEG_MAX     = 32;
  localparam int CNT_W       = $clog2(SEG_MAX);

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_PRE,
    SEG_CMD,
    SEG_CAP,
    SEG_TAIL
  } seg_e;

  // Start 01, opcode (01 write / 10 read), addresses, turnaround 10, data.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] ra,
    input logic [DATA_W-1:0] d
  );
    return {2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R3: a phase never exceeds HALF_DIV cycles
  assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/mdio_bit_seq.sv
module mdio_bit_seq
  import mdio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_read,
  input  logic tick,
  output seg_e seg,
  output logic mdc,
  output logic bit_adv,
  output logic sample,
  output logic done
);
  logic [CNT_W-1:0] bit_idx;
  int               seg_len;
  logic             last_bit;

  always_comb begin
    case (seg)
      SEG_PRE: seg_len = PRE_BITS;
      SEG_CMD: seg_len = is_read ? RD_CMD_BITS : FRAME_BITS;
      SEG_CAP: seg_len = CAP_BITS;
      default: seg_len = TAIL_BITS;
    endcase
    last_bit = (bit_idx == CNT_W'(seg_len - 1));
  end

  assign bit_adv = tick && mdc;
  assign sample  = tick && !mdc && (seg == SEG_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg     <= SEG_IDLE;
      mdc     <= 1'b1;
      bit_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (seg == SEG_IDLE) begin
        if (start) begin
          seg     <= SEG_PRE;
          mdc     <= 1'b0;
          bit_idx <= '0;
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
        end else if (!last_bit) begin
          bit_idx <= bit_idx + 1'b1;
          mdc     <= 1'b0;
        end else begin
          bit_idx <= '0;
          case (seg)
            SEG_PRE: begin seg <= SEG_CMD; mdc <= 1'b0; end
            SEG_CMD: begin seg <= is_read ? SEG_CAP : SEG_TAIL; mdc <= 1'b0; end
            SEG_CAP: begin seg <= SEG_TAIL; mdc <= 1'b0; end
            default: begin seg <= SEG_IDLE; done <= 1'b1; end
          endcase
        end
      end
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: the clock rests high between transactions
  assert_idle_mdc_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_IDLE) |-> mdc);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  seg_e                  seg;
  logic                  busy, accept, tick, bit_adv, sample, done;
  logic                  is_read;
  logic [FRAME_BITS-1:0] cmd_sr;
  logic [DATA_W-1:0]     cap_sr;

  assign busy      = (seg != SEG_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  mdio_bit_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .is_read(is_read),
    .tick   (tick),
    .seg    (seg),
    .mdc    (mdc),
    .bit_adv(bit_adv),
    .sample (sample),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_read <= 1'b0;
      cmd_sr  <= '0;
      cap_sr  <= '0;
    end else if (accept) begin
      is_read <= !req_write;
      cmd_sr  <= build_frame(req_write, req_phy, req_reg, req_wdata);
      cap_sr  <= '0;
    end else begin
      if (bit_adv && seg == SEG_CMD) cmd_sr <= {cmd_sr[FRAME_BITS-2:0], 1'b0};
      // 18 samples pass through a 16-bit register: the first two fall off
      if (sample) cap_sr <= {cap_sr[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_o    = (seg == SEG_CMD) ? cmd_sr[FRAME_BITS-1] : 1'b1;
  assign mdio_oe   = busy && (seg != SEG_CAP);
  assign rsp_valid = done;
  assign rsp_rdata = cap_sr;

  // R3: the data line only moves while the clock is low
  assert_mdio_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));
  // R6: only reads release the line during a transaction
  assert_release_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> is_read);
  // R2: a transaction begins only from a presented request
  assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R1: drive enable is off when idle
  assert_idle_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && !busy |-> !mdio_oe);
endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
  localparam int H   = 4;
  localparam int NT  = 6;
  localparam int WD  = 20000;
  localparam int TXN = 192 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mdio_i = 1'b1;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  always #4 clk = ~clk;

  mdio_frame_master #(.HALF_DIV(H)) i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  logic        t_wr [NT] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  logic [4:0]  t_phy[NT] = '{5'd1, 5'd31, 5'd0, 5'd31, 5'd10, 5'd21};
  logic [4:0]  t_reg[NT] = '{5'd0, 5'd31, 5'd0, 5'd17, 5'd5, 5'd10};
  logic [15:0] t_wd [NT] = '{16'hA5C3, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000};
  logic [17:0] t_pat[NT] = '{18'h0, 18'h3_1234, 18'h0_FFFF, 18'h0, 18'h0, 18'h2_8001};
  int          t_gap[NT] = '{2, 5, 0, 3, 0, 1};

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit          m_act = 0, m_done = 0, m_rd = 0;
  int          m_t = 0;
  logic [31:0] m_frm = '0;
  logic [17:0] m_pat = '0;

  initial begin
    int idx = 0, gap = 0, cyc = 0, tail = 0;
    gap = t_gap[0];
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 mdc", {31'd0, mdc}, 32'd1);
      chk("R1 mdio_oe", {31'd0, mdio_oe}, 32'd0);
      chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    end
    rst_n = 1'b1;
    while (tail < 6) begin
      int bitn, hi;
      bit e_oe, e_o;
      @(negedge clk);
      cyc++;
      if (cyc > WD) begin
        errors++;
        $display("FAIL watchdog expired");
        break;
      end
      // reference comparison for this cycle
      if (m_act) begin
        bitn = m_t / (2 * H);
        hi   = (m_t / H) % 2;
        e_oe = !(m_rd && bitn >= 46 && bitn < 64);
        if (bitn < 32)      e_o = 1'b1;
        else if (bitn < 64) e_o = m_frm[31 - (bitn - 32)];
        else                e_o = 1'b1;
        chk("R3 mdc", {31'd0, mdc}, hi);
        chk(bitn < 32 ? "R4 mdio_oe" : (bitn < 64 ? "R6 mdio_oe" : "R8 mdio_oe"),
            {31'd0, mdio_oe}, {31'd0, e_oe});
        if (e_oe)
          chk(bitn < 32 ? "R4 mdio_o" : (bitn >= 64 ? "R8 mdio_o" :
              (m_rd ? "R6 mdio_o" : "R5 mdio_o")), {31'd0, mdio_o}, {31'd0, e_o});
        chk("R2 req_ready", {31'd0, req_ready}, 32'd0);
        chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      end else begin
        chk("R1 mdc", {31'd0, mdc}, 32'd1);
        chk("R1 mdio_oe", {31'd0, mdio_oe}, 32'd0);
        chk("R2 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R9 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_done});
        if (m_done && m_rd) chk("R7 rsp_rdata", {16'd0, rsp_rdata}, {16'd0, m_pat[15:0]});
      end
      // PHY model: answer during released low phases
      mdio_i = 1'b1;
      if (m_act && m_rd) begin
        bitn = m_t / (2 * H);
        if (bitn >= 46 && bitn < 64) mdio_i = m_pat[17 - (bitn - 46)];
      end
      // stimulus
      req_valid = 1'b0;
      if (m_act && m_t == 300) begin
        // R2: request while busy must be ignored
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h15;
        req_reg = 5'h0A; req_wdata = 16'h5A5A;
      end else if (!m_act && idx < NT) begin
        if (gap == 0) begin
          req_valid = 1'b1; req_write = t_wr[idx]; req_phy = t_phy[idx];
          req_reg = t_reg[idx]; req_wdata = t_wd[idx];
        end else gap--;
      end
      // reference update for the next cycle
      m_done = 0;
      if (m_act) begin
        m_t++;
        if (m_t == TXN) begin m_act = 0; m_done = 1; end
      end else if (req_valid) begin
        m_act = 1; m_t = 0; m_rd = !t_wr[idx];
        m_frm = {2'b01, (t_wr[idx] ? 2'b01 : 2'b10), t_phy[idx], t_reg[idx], 2'b10, t_wd[idx]};
        m_pat = t_pat[idx];
        idx++;
        if (idx < NT) gap = t_gap[idx];
      end
      if (idx == NT && !m_act && !m_done) tail++;
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule